// File: doc/BRIEF.md
# Gate-Qualified Synchronous FIFO

This block is a small first-in first-out queue whose state updates are qualified by a composed clock-gate signal. The gating is modelled as an enable inside one physical clock. The effective gate starts from a parent gate. Each level of nesting then ANDs in one more local condition, so a two-level chain gives `parent_gate && local_cond[0] && local_cond[1]`.

Three state-changing operations are offered: push, pop and flush. Each has its own ready output, and all three readies are masked by the effective gate. An operation whose gate is off does not take effect, even when its request is high.

The read-only outputs are not masked. These are the head value, its valid flag and the full and empty flags. A non-empty queue therefore keeps presenting its oldest entry while the gate is off. The intended use is a queue in a power-managed region: upstream logic keeps reading the head while the region is gated, and no new traffic is accepted until the gate returns.

Top module: `gated_fifo`

## Requirements
- R1: While `rst` is high at a rising clock edge, the queue becomes empty: `empty`=1, `full`=0, `head_valid`=0. This happens whatever the gate inputs and requests are.
- R2: The effective gate is `parent_gate` ANDed with every bit of `local_cond`. If any one of them is low, the gate is off.
- R3: `push_rdy` is gate AND not full, `pop_rdy` is gate AND not empty, and `flush_rdy` is the gate alone. All three are combinational from the current state and inputs.
- R4: While the gate is off, push, pop and flush requests are ignored, and `full`, `empty`, `head_valid` and `head_data` keep their values.
- R5: A queue that holds data keeps `head_valid`=1 and an unchanged `head_data` through any number of gate-off cycles.
- R6: Entries leave in the order they were pushed. A push into an empty queue appears on `head_data` with `head_valid`=1 after the same clock edge.
- R7: A push and a pop in the same gated-on cycle on a queue that is neither empty nor full keep the occupancy unchanged. The head advances to the next older entry.
- R8: A flush in a gated-on cycle empties the queue. It takes priority over a push or pop in the same cycle.
- R9: A push while full, or a pop while empty, has no effect.
- R10: `full` is 1 exactly when DEPTH entries are held, and `empty` is 1 exactly when none are held. The default DEPTH is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, not gated |
| parent_gate | input | 1 | Gate of the parent clock |
| local_cond | input | LEVELS | One local gate condition per nesting level |
| push_req | input | 1 | Push request |
| push_data | input | DATA_W | Data to push |
| pop_req | input | 1 | Pop request |
| flush_req | input | 1 | Flush request |
| push_rdy | output | 1 | Push would be accepted |
| pop_rdy | output | 1 | Pop would be accepted |
| flush_rdy | output | 1 | Flush would be accepted |
| head_data | output | DATA_W | Oldest entry |
| head_valid | output | 1 | head_data holds a real entry |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |

## Verification
A gate leak shows at the ports on the edge that follows the gate-off cycle. The symptoms are a flag that flips, a head value that moves, or a ready that is high with the gate off. Each directed step checks the readies in the middle of the cycle. It checks the flags and head one edge later. An occupancy error or pointer slip therefore shows up as a wrong flag or a wrong head value within one cycle of the faulty update. Order errors may take a little longer to appear: they show when the misplaced entry reaches the head, which is at most DEPTH pops later.

// File: rtl/gfifo_pkg.sv
package gfifo_pkg;

    // Operations granted in one cycle after gating and priority.
    typedef struct packed {
        logic flush;
        logic push;
        logic pop;
    } fifo_op_t;

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/gfifo_gate.sv
module gfifo_gate #(
    parameter int LEVELS = 2
) (
    input  logic              parent_gate,
    input  logic [LEVELS-1:0] local_cond,
    output logic              eff_gate
);
    logic [LEVELS:0] chain;

    assign chain[0] = parent_gate;
    for (genvar i = 0; i < LEVELS; i++) begin : g_level
        assign chain[i+1] = chain[i] & local_cond[i];
    end
    assign eff_gate = chain[LEVELS];
endmodule

// File: rtl/gfifo_ctrl.sv
module gfifo_ctrl
    import gfifo_pkg::*;
(
    input  logic     eff_gate,
    input  logic     push_req,
    input  logic     pop_req,
    input  logic     flush_req,
    input  logic     is_full,
    input  logic     is_empty,
    output logic     push_rdy,
    output logic     pop_rdy,
    output logic     flush_rdy,
    output fifo_op_t op
);
    always_comb begin
        push_rdy  = eff_gate & ~is_full;
        pop_rdy   = eff_gate & ~is_empty;
        flush_rdy = eff_gate;
        op.flush  = flush_req & flush_rdy;
        op.push   = push_req & push_rdy & ~op.flush;
        op.pop    = pop_req & pop_rdy & ~op.flush;
    end
endmodule

// File: rtl/gfifo_store.sv
module gfifo_store
    import gfifo_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  fifo_op_t          op,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] head_data,
    output logic              is_full,
    output logic              is_empty
);
    localparam int PTR_W = ptr_bits(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (op.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (op.push) begin
                mem[wr_ptr] <= wr_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (op.pop) rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(op.push) - CNT_W'(op.pop);
        end
    end

    assign head_data = mem[rd_ptr];
    assign is_full   = (count == CNT_W'(DEPTH));
    assign is_empty  = (count == '0);
endmodule

// File: rtl/gated_fifo.sv
module gated_fifo
    import gfifo_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int DATA_W = 8,
    parameter int LEVELS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              parent_gate,
    input  logic [LEVELS-1:0] local_cond,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              flush_req,
    output logic              push_rdy,
    output logic              pop_rdy,
    output logic              flush_rdy,
    output logic [DATA_W-1:0] head_data,
    output logic              head_valid,
    output logic              full,
    output logic              empty
);
    logic     eff_gate;
    fifo_op_t op;

    gfifo_gate #(.LEVELS(LEVELS)) u_gate (
        .parent_gate (parent_gate),
        .local_cond  (local_cond),
        .eff_gate    (eff_gate)
    );

    gfifo_ctrl u_ctrl (
        .eff_gate  (eff_gate),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .flush_req (flush_req),
        .is_full   (full),
        .is_empty  (empty),
        .push_rdy  (push_rdy),
        .pop_rdy   (pop_rdy),
        .flush_rdy (flush_rdy),
        .op        (op)
    );

    gfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wr_data   (push_data),
        .head_data (head_data),
        .is_full   (full),
        .is_empty  (empty)
    );

    assign head_valid = ~empty;
endmodule

// File: rtl/gated_fifo_chk.sv
module gated_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int LEVELS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              parent_gate,
    input logic [LEVELS-1:0] local_cond,
    input logic              push_req,
    input logic              pop_req,
    input logic              flush_req,
    input logic              push_rdy,
    input logic              pop_rdy,
    input logic              flush_rdy,
    input logic [DATA_W-1:0] head_data,
    input logic              head_valid,
    input logic              full,
    input logic              empty
);
    logic gate_on;
    assign gate_on = parent_gate & (&local_cond);

    a_r1_reset_empties: assert property (@(posedge clk)
        rst |=> (empty && !full && !head_valid));

    a_r2_r3_rdy_masked: assert property (@(posedge clk) disable iff (rst)
        !gate_on |-> (!push_rdy && !pop_rdy && !flush_rdy));

    a_r4_gate_off_frozen: assert property (@(posedge clk) disable iff (rst)
        !gate_on |=> ($stable(full) && $stable(empty) && $stable(head_valid)));

    a_r5_head_persists: assert property (@(posedge clk) disable iff (rst)
        (!gate_on && head_valid) |=> (head_valid && $stable(head_data)));

    a_r8_flush_wins: assert property (@(posedge clk) disable iff (rst)
        (flush_req && flush_rdy) |=> empty);

    a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !push_rdy);

    a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        empty |-> (!pop_rdy && !head_valid));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    a_r6_push_shows: assert property (@(posedge clk) disable iff (rst)
        (push_req && push_rdy && !flush_req) |=> head_valid);
endmodule

bind gated_fifo gated_fifo_chk #(.DATA_W(DATA_W), .LEVELS(LEVELS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .parent_gate (parent_gate),
    .local_cond  (local_cond),
    .push_req    (push_req),
    .pop_req     (pop_req),
    .flush_req   (flush_req),
    .push_rdy    (push_rdy),
    .pop_rdy     (pop_rdy),
    .flush_rdy   (flush_rdy),
    .head_data   (head_data),
    .head_valid  (head_valid),
    .full        (full),
    .empty       (empty)
);

// File: tb/gated_fifo_tb_top.sv
module gated_fifo_tb_top;
    localparam int DEPTH  = 2;
    localparam int DATA_W = 8;
    localparam int LEVELS = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              parent_gate = 1'b0;
    logic [LEVELS-1:0] local_cond = '0;
    logic              push_req = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic              pop_req = 1'b0;
    logic              flush_req = 1'b0;
    logic              push_rdy, pop_rdy, flush_rdy, head_valid, full, empty;
    logic [DATA_W-1:0] head_data;

    int n_vec = 0;
    int n_bad = 0;
    int model[$];

    always #10 clk = ~clk;

    gated_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LEVELS(LEVELS)) dut_i (
        .clk(clk), .rst(rst), .parent_gate(parent_gate), .local_cond(local_cond),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
        .flush_req(flush_req), .push_rdy(push_rdy), .pop_rdy(pop_rdy),
        .flush_rdy(flush_rdy), .head_data(head_data), .head_valid(head_valid),
        .full(full), .empty(empty)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check(req, {full, empty, head_valid},
              {model.size() == DEPTH, model.size() == 0, model.size() > 0});
        if (model.size() > 0) check(req, head_data, model[0]);
    endtask

    // One cycle: drive at negedge, check readies mid-cycle, state after the edge.
    task automatic step(input logic p, input logic [DATA_W-1:0] d,
                        input logic q, input logic f, input string req);
        logic g;
        logic do_pop, do_push;
        g = parent_gate & (&local_cond);
        push_req = p; push_data = d; pop_req = q; flush_req = f;
        #2;
        check({req, "/R3 ready"}, {push_rdy, pop_rdy, flush_rdy},
              {g && model.size() < DEPTH, g && model.size() > 0, g});
        @(negedge clk);
        if (g) begin
            if (f) model.delete();
            else begin
                do_pop  = q && model.size() > 0;
                do_push = p && model.size() < DEPTH;
                if (do_pop) void'(model.pop_front());
                if (do_push) model.push_back(int'(d));
            end
        end
        push_req = 1'b0; pop_req = 1'b0; flush_req = 1'b0;
        check_state(req);
    endtask

    task automatic t_reset();
        rst = 1'b1; push_req = 1'b1; parent_gate = 1'b0;
        repeat (2) @(negedge clk);
        push_req = 1'b0;
        model.delete();
        check_state("R1 reset");
        rst = 1'b0;
        parent_gate = 1'b1; local_cond = '1;
        #2;
        check("R1 R3 ready after reset", {push_rdy, pop_rdy, flush_rdy}, 3'b101);
        @(negedge clk);
    endtask

    task automatic t_fill();
        step(1, 8'hA1, 0, 0, "R6 push into empty");
        step(1, 8'hB2, 0, 0, "R10 full at depth");
        step(1, 8'hC3, 0, 0, "R9 push while full");
        check("R10 full flag", full, 1);
    endtask

    task automatic t_gate_off();
        parent_gate = 1'b0;
        step(0, 0, 1, 0, "R4 pop parent off");
        step(0, 0, 0, 1, "R4 flush parent off");
        repeat (3) step(0, 0, 0, 0, "R5 head held");
        parent_gate = 1'b1; local_cond = 2'b01;
        step(0, 0, 1, 1, "R2 level1 off");
        local_cond = 2'b10;
        step(0, 0, 1, 1, "R2 level0 off");
        check("R5 head persists", head_data, 8'hA1);
        local_cond = 2'b11;
        step(0, 0, 1, 0, "R6 pop order");
        check("R6 second entry", head_data, 8'hB2);
    endtask

    task automatic t_simul();
        step(1, 8'hD4, 1, 0, "R7 push+pop");
        check("R7 occupancy", {full, empty}, 2'b00);
        step(1, 8'hE5, 0, 0, "R6 refill");
        step(0, 0, 1, 0, "R6 wrap order");
        check("R6 wrap head", head_data, 8'hE5);
    endtask

    task automatic t_flush();
        step(1, 8'h16, 0, 0, "R10 refill");
        step(1, 8'h27, 1, 1, "R8 flush priority");
        check("R8 empty after flush", empty, 1);
        step(0, 0, 1, 0, "R9 pop while empty");
        local_cond = 2'b00;
        step(1, 8'h38, 0, 0, "R4 push gate off");
        local_cond = 2'b11;
        step(1, 8'h49, 0, 0, "R6 push after gate on");
    endtask

    task automatic t_reset_gate_off();
        parent_gate = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model.delete();
        check_state("R1 reset ignores gate");
        parent_gate = 1'b1;
    endtask

    initial begin
        t_reset();
        t_fill();
        t_gate_off();
        t_simul();
        t_flush();
        t_reset_gate_off();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule